// File: doc/BRIEF.md
# Compare/PWM Timer

An 8-bit up-counting timer that advances on one of several externally supplied prescaler tap enables. A 4-bit clock-select field picks which tap advances the counter. Selecting zero halts it. A small register interface gives software access to the counter, two compare registers, a control register, a flag register, an interrupt-enable register and a strobe register. The strobe register forces a compare action or restarts the external prescale divider.

In normal mode only compare register A is used. When the count equals A on a tick, the block applies the configured output action, sets the compare flag and can optionally clear the counter. In PWM mode, register B sets the period: the counter wraps from B to 0. Register A sets the duty. A new A value is held in a temporary register and moves into the active comparator only at the wrap, so a write in mid-period cannot cause an output glitch. A read of A still returns the newest written value at once.

The interrupt request outputs are the flags gated by their enable bits. Interrupt vectoring and pin multiplexing belong to the surrounding logic.

Top module: `cmp_pwm_timer`

## Requirements
- R1: The clock-select field is control bits [3:0]. The value 0 stops the counter. A value n in 1..15 advances it once on each clock edge where tap_en[n-1] is high.
- R2: A write to address 0 loads the counter at that edge and does not count in that cycle. Counting resumes on the next tick. A read of address 0 returns the count.
- R3: In normal mode (control bit 7 = 0), a match occurs on a tick when the count equals the active A value. A match sets the compare flag (flag register, address 4, bit 0). If control bit 6 is 1, the match loads 0 into the counter instead of incrementing it.
- R4: In normal mode, a tick at count 255 that is not a clearing match wraps the counter to 0 and sets the overflow flag (address 4, bit 1).
- R5: The compare-mode field is control bits [5:4]. Its values are: 00 no action, 01 toggle cmp_out, 10 drive it to 0, 11 drive it to 1, each applied on a match. cmp_oe is high whenever the field is non-zero.
- R6: In PWM mode (control bit 7 = 1), the counter runs from 0 to B (address 2) and then wraps to 0, so the period is B+1 ticks. The wrap sets the overflow flag. With mode 10, the wrap sets cmp_out to 1 and the A match clears it, so the output is high for A+1 ticks of each period. With mode 11 the wrap clears cmp_out.
- R7: In PWM mode, a write to A (address 1) is held and reaches the comparator only at the next wrap. In normal mode it takes effect at once. A read of address 1 always returns the last value written.
- R8: Writing 1 to bit 0 of address 6 applies the compare-mode action to cmp_out at that edge, without a match and without setting the compare flag. Address 6 reads as 0.
- R9: A flag is cleared by writing 1 to its bit at address 4 or by its acknowledge input (ack_cmp, ack_ovf). A hardware set in the same cycle wins over the clear.
- R10: irq_cmp equals the compare flag AND enable bit 0 of address 5. irq_ovf equals the overflow flag AND enable bit 1 of address 5.
- R11: Writing 1 to bit 1 of address 6 makes psc_rst high for exactly one cycle.
- R12: After reset, all registers, the counter, both flags and cmp_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_en | input | TAPS | Prescaler tap enables, one per selectable rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Read data (combinational) |
| ack_cmp | input | 1 | Acknowledge that clears the compare flag |
| ack_ovf | input | 1 | Acknowledge that clears the overflow flag |
| cmp_out | output | 1 | Compare output level |
| cmp_oe | output | 1 | Compare output enable (mode non-zero) |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| psc_rst | output | 1 | One-cycle restart pulse for the prescale divider |

## Verification
The hardest case to reach is a duty write that lands after the period has begun, before the old match point. It must take effect only after the wrap, even though a read already returns the new value. The stimulus first aligns to the wrap by polling the count. It then writes A one tick into the period and reads A back at once. Next it checks that the output still falls at the old match point. Finally it measures the high time of the following period against the new value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        CM_OFF = 2'b00,
        CM_TOG = 2'b01,
        CM_CLR = 2'b10,
        CM_SET = 2'b11
    } cmp_mode_e;

    localparam logic [2:0] AD_CNT  = 3'd0;
    localparam logic [2:0] AD_OCRA = 3'd1;
    localparam logic [2:0] AD_OCRB = 3'd2;
    localparam logic [2:0] AD_CTRL = 3'd3;
    localparam logic [2:0] AD_FLAG = 3'd4;
    localparam logic [2:0] AD_IEN  = 3'd5;
    localparam logic [2:0] AD_STRB = 3'd6;

    // Output level after a compare action in the given mode.
    function automatic logic cm_apply(cmp_mode_e m, logic cur);
        case (m)
            CM_TOG:  return ~cur;
            CM_CLR:  return 1'b0;
            CM_SET:  return 1'b1;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int TAPS = 15,
    parameter int SELW = 4
) (
    input  logic [TAPS-1:0] tap_en,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    logic [TAPS-1:0] hit;

    // One gate per tap; the select value 0 matches no tap, so the counter halts.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign hit[i] = tap_en[i] && (sel == SELW'(i + 1));
    end

    assign tick = |hit;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwm,
    input  logic          ctc,
    input  cmp_mode_e     mode,
    input  logic [CW-1:0] top_b,
    input  logic          cnt_wr,
    input  logic [CW-1:0] wdata,
    input  logic          a_wr,
    input  logic [CW-1:0] a_buf,
    input  logic          force_cmp,
    input  logic [1:0]    flag_clr,
    input  logic          ack_cmp,
    input  logic          ack_ovf,
    output logic [CW-1:0] cnt,
    output logic          out,
    output logic          flag_cmp,
    output logic          flag_ovf
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] act;
        logic          out;
        logic          fc;
        logic          fo;
    } st_t;

    st_t  st_d, st_q;
    logic match, wrap, ovf_hit;

    always_comb begin
        st_d    = st_q;
        match   = tick && (st_q.cnt == st_q.act);
        wrap    = pwm && tick && (st_q.cnt == top_b);
        ovf_hit = !pwm && tick && (st_q.cnt == '1) && !(match && ctc);

        if (tick) begin
            if (pwm)
                st_d.cnt = wrap ? '0 : st_q.cnt + CW'(1);
            else
                st_d.cnt = (match && ctc) ? '0 : st_q.cnt + CW'(1);
        end
        if (cnt_wr)
            st_d.cnt = wdata;

        if (a_wr && !pwm)
            st_d.act = wdata;
        else if (wrap)
            st_d.act = a_buf;

        if (wrap && mode == CM_CLR)
            st_d.out = 1'b1;
        else if (wrap && mode == CM_SET)
            st_d.out = 1'b0;
        if (match)
            st_d.out = cm_apply(mode, st_d.out);
        if (force_cmp)
            st_d.out = cm_apply(mode, st_q.out);

        if (flag_clr[0] || ack_cmp)
            st_d.fc = 1'b0;
        if (match)
            st_d.fc = 1'b1;
        if (flag_clr[1] || ack_ovf)
            st_d.fo = 1'b0;
        if (ovf_hit || wrap)
            st_d.fo = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign out      = st_q.out;
    assign flag_cmp = st_q.fc;
    assign flag_ovf = st_q.fo;

    // R1: without a tick or a write the count holds
    a_r1_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(st_q.cnt));
    // R3: clearing match loads zero
    a_r3_ctc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pwm && ctc && !cnt_wr && st_q.cnt == st_q.act) |=> (st_q.cnt == '0));
    // R3: match raises the compare flag
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == st_q.act) |=> st_q.fc);
    // R6: PWM period ends at B
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && tick && !cnt_wr && st_q.cnt == top_b) |=> (st_q.cnt == '0));
    // R7: in PWM mode the active duty only moves at the wrap
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !(tick && st_q.cnt == top_b)) |=> $stable(st_q.act));
    // R9: acknowledge clears the compare flag when no match competes
    a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmp && !(tick && st_q.cnt == st_q.act)) |=> !st_q.fc);
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
    import tmr_pkg::*;
#(
    parameter int CW   = 8,
    parameter int TAPS = 15,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TAPS-1:0] tap_en,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [CW-1:0]   rd_data,
    input  logic            ack_cmp,
    input  logic            ack_ovf,
    output logic            cmp_out,
    output logic            cmp_oe,
    output logic            irq_cmp,
    output logic            irq_ovf,
    output logic            psc_rst
);
    localparam int SELW = $clog2(TAPS + 1);

    typedef struct packed {
        logic [CW-1:0] a_tmp;
        logic [CW-1:0] b;
        logic [CW-1:0] ctrl;
        logic [1:0]    ien;
        logic          psc;
    } rg_t;

    rg_t           rg_d, rg_q;
    logic          tick, a_wr, cnt_wr, force_cmp;
    logic [1:0]    flag_clr;
    logic [CW-1:0] cnt;
    logic          flag_cmp, flag_ovf;
    cmp_mode_e     mode;

    assign mode = cmp_mode_e'(rg_q.ctrl[5:4]);

    always_comb begin
        rg_d      = rg_q;
        rg_d.psc  = 1'b0;
        cnt_wr    = wr_en && (wr_addr == AD_CNT);
        a_wr      = wr_en && (wr_addr == AD_OCRA);
        force_cmp = wr_en && (wr_addr == AD_STRB) && wr_data[0];
        flag_clr  = (wr_en && (wr_addr == AD_FLAG)) ? wr_data[1:0] : 2'b00;
        if (a_wr)                            rg_d.a_tmp = wr_data;
        if (wr_en && wr_addr == AD_OCRB)     rg_d.b     = wr_data;
        if (wr_en && wr_addr == AD_CTRL)     rg_d.ctrl  = wr_data;
        if (wr_en && wr_addr == AD_IEN)      rg_d.ien   = wr_data[1:0];
        if (wr_en && wr_addr == AD_STRB)     rg_d.psc   = wr_data[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    tmr_tick_sel #(.TAPS(TAPS), .SELW(SELW)) u_sel (
        .tap_en (tap_en),
        .sel    (rg_q.ctrl[SELW-1:0]),
        .tick   (tick)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pwm       (rg_q.ctrl[7]),
        .ctc       (rg_q.ctrl[6]),
        .mode      (mode),
        .top_b     (rg_q.b),
        .cnt_wr    (cnt_wr),
        .wdata     (wr_data),
        .a_wr      (a_wr),
        .a_buf     (a_wr ? wr_data : rg_q.a_tmp),
        .force_cmp (force_cmp),
        .flag_clr  (flag_clr),
        .ack_cmp   (ack_cmp),
        .ack_ovf   (ack_ovf),
        .cnt       (cnt),
        .out       (cmp_out),
        .flag_cmp  (flag_cmp),
        .flag_ovf  (flag_ovf)
    );

    always_comb begin
        case (rd_addr)
            AD_CNT:  rd_data = cnt;
            AD_OCRA: rd_data = rg_q.a_tmp;
            AD_OCRB: rd_data = rg_q.b;
            AD_CTRL: rd_data = rg_q.ctrl;
            AD_FLAG: rd_data = CW'({flag_ovf, flag_cmp});
            AD_IEN:  rd_data = CW'(rg_q.ien);
            default: rd_data = '0;
        endcase
    end

    assign cmp_oe  = (mode != CM_OFF);
    assign irq_cmp = flag_cmp & rg_q.ien[0];
    assign irq_ovf = flag_ovf & rg_q.ien[1];
    assign psc_rst = rg_q.psc;

    // R11: divider restart is a single-cycle pulse
    a_r11_psc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_rst && !(wr_en && wr_addr == AD_STRB && wr_data[1])) |=> !psc_rst);
    // R8: strobe register never reads back a one
    a_r8_strb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AD_STRB) |-> (rd_data == '0));
endmodule

// File: tb/sim_cmp_pwm_timer.sv
module sim_cmp_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tap1 = 1'b0;
    logic [14:0] tap_en;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        ack_cmp = 1'b0, ack_ovf = 1'b0;
    logic        cmp_out, cmp_oe, irq_cmp, irq_ovf, psc_rst;
    int          errs = 0, checks = 0;

    assign tap_en = {13'b0, tap1, 1'b1};

    always #10 clk = ~clk;

    cmp_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .tap_en(tap_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ack_cmp(ack_cmp), .ack_ovf(ack_ovf),
        .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq_cmp(irq_cmp),
        .irq_ovf(irq_ovf), .psc_rst(psc_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_wrap();
        int v;
        for (int i = 0; i < 40; i++) begin
            rd(3'd0, v);
            if (v == 0 && cmp_out) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R12 reg %0d", a), v, 0);
        end
        chk("R12 cmp_out", cmp_out, 0);
        chk("R12 irq", {irq_cmp, irq_ovf}, 0);
    endtask

    task automatic t_stop_count();
        int v;
        wr(3'd0, 8'd5);
        repeat (5) @(negedge clk);
        rd(3'd0, v); chk("R1 stopped", v, 5);
        wr(3'd3, 8'h01);
        rd(3'd0, v); chk("R1 no count at select edge", v, 5);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R1 tap0 count", v, 8);
        wr(3'd0, 8'd100);
        rd(3'd0, v); chk("R2 load", v, 100);
        @(negedge clk);
        rd(3'd0, v); chk("R2 resume", v, 101);
    endtask

    task automatic t_tap();
        int v, base;
        wr(3'd3, 8'h02);
        rd(3'd0, base);
        repeat (5) @(negedge clk);
        rd(3'd0, v); chk("R1 tap1 idle", v, base);
        for (int k = 0; k < 3; k++) begin
            tap1 = 1'b1; @(negedge clk);
            tap1 = 1'b0; @(negedge clk);
        end
        rd(3'd0, v); chk("R1 tap1 pulses", v, base + 3);
    endtask

    task automatic t_normal_ctc();
        int v;
        wr(3'd3, 8'h00);
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h03);
        wr(3'd3, 8'h51);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R3 count to A", v, 3);
        chk("R5 before match", cmp_out, 0);
        chk("R5 oe", cmp_oe, 1);
        @(negedge clk);
        rd(3'd0, v); chk("R3 clear on match", v, 0);
        chk("R5 toggle high", cmp_out, 1);
        rd(3'd4, v); chk("R3 flag", v & 1, 1);
        repeat (4) @(negedge clk);
        chk("R5 toggle low", cmp_out, 0);
    endtask

    task automatic t_flags();
        int v;
        wr(3'd3, 8'h50);
        wr(3'd5, 8'h01);
        chk("R10 irq_cmp on", irq_cmp, 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R9 w1c", v & 1, 0);
        chk("R10 irq_cmp off", irq_cmp, 0);
        wr(3'd0, 8'd3);
        wr(3'd3, 8'h51);
        @(negedge clk);
        wr(3'd3, 8'h50);
        rd(3'd4, v); chk("R3 flag again", v & 1, 1);
        ack_cmp = 1'b1; @(negedge clk); ack_cmp = 1'b0;
        rd(3'd4, v); chk("R9 ack clears", v & 1, 0);
    endtask

    task automatic t_overflow();
        int v;
        wr(3'd3, 8'h00);
        wr(3'd0, 8'hFD);
        wr(3'd4, 8'h03);
        wr(3'd5, 8'h02);
        wr(3'd3, 8'h01);
        repeat (2) @(negedge clk);
        rd(3'd4, v); chk("R4 no early ovf", v & 2, 0);
        @(negedge clk);
        rd(3'd0, v); chk("R4 wrap", v, 0);
        rd(3'd4, v); chk("R4 ovf flag", v & 2, 2);
        chk("R10 irq_ovf", irq_ovf, 1);
        wr(3'd3, 8'h00);
        ack_ovf = 1'b1; @(negedge clk); ack_ovf = 1'b0;
        rd(3'd4, v); chk("R9 ack ovf", v & 2, 0);
    endtask

    task automatic t_force();
        int v;
        wr(3'd4, 8'h03);
        wr(3'd3, 8'h30);
        wr(3'd6, 8'h01);
        chk("R8 force set", cmp_out, 1);
        rd(3'd4, v); chk("R8 no flag", v, 0);
        rd(3'd6, v); chk("R8 reads zero", v, 0);
        wr(3'd3, 8'h20);
        wr(3'd6, 8'h01);
        chk("R8 force clear", cmp_out, 0);
        wr(3'd3, 8'h00);
        chk("R5 oe off", cmp_oe, 0);
        wr(3'd6, 8'h02);
        chk("R11 pulse high", psc_rst, 1);
        @(negedge clk);
        chk("R11 pulse low", psc_rst, 0);
    endtask

    task automatic t_pwm();
        int v, hi;
        wr(3'd1, 8'd3);
        wr(3'd2, 8'd9);
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h03);
        wr(3'd3, 8'hA1);
        wait_wrap();
        rd(3'd4, v); chk("R6 ovf at wrap", v & 2, 2);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (cmp_out) hi++;
            @(negedge clk);
        end
        chk("R6 duty A+1", hi, 4);
        rd(3'd0, v); chk("R6 period B+1", v, 0);
        chk("R6 high at wrap", cmp_out, 1);
        wr(3'd1, 8'd6);
        rd(3'd1, v); chk("R7 read newest", v, 6);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R7 position", v, 4);
        chk("R7 old duty still active", cmp_out, 0);
        wait_wrap();
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (cmp_out) hi++;
            @(negedge clk);
        end
        chk("R7 new duty after wrap", hi, 7);
    endtask

    initial begin
        #(200000 * 20);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_count();
        t_tap();
        t_normal_ctc();
        t_flags();
        t_overflow();
        t_force();
        t_pwm();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule